// File: doc/BRIEF.md
# Hardware Mutex Flag Bank

This block is a bus-attached bank of mutual-exclusion flags shared by several processors. Each flag sits in its own 32-bit word. A read of that word is a test-and-set: it returns the flag's previous state and leaves the flag taken, all in one clock cycle. A processor that reads 0 now owns the flag. A processor that reads 1 lost the race and may poll again later. Writing 0 to the word frees the flag. A read-only status word reports how many flags the bank implements, so software can size its tables at start-up.

The bus side is a plain 32-bit register interface. One access is presented per cycle on `bus_rd` or `bus_wr`. The block answers with `bus_ready` and `bus_rdata` exactly one cycle later. The flag count is the parameter `NUM_LOCKS`, which may be 32, 64, 128 or 256. The status field is derived from that parameter.

Top module: `hw_mutex_bank`

## Requirements
- R1: After reset every flag is free, and `bus_ready` and `bus_rdata` are 0.
- R2: `bus_ready` is 1 in the cycle after any cycle with `bus_rd` or `bus_wr` high, and 0 otherwise. `bus_rdata` is 0 whenever `bus_ready` is 0 and after any write.
- R3: A read of the flag word at byte address 0x800 + 4*i (i < NUM_LOCKS) that finds flag i free returns 32'h0 and leaves flag i taken.
- R4: A read of a taken flag word returns 32'h1 and changes no flag, so repeated polling is harmless.
- R5: Writing 32'h0 to the word of flag i frees flag i and no other flag.
- R6: Writing any nonzero value to a flag word changes no flag.
- R7: A read of byte address 0x014 returns NUM_LOCKS/32 in bits 27:24 (one-hot: 1, 2, 4 or 8) and 0 in all other bits. A read or write of that address changes no flag.
- R8: Reads of any other address return 0 and change no flag. This includes addresses at or beyond 0x800 + 4*NUM_LOCKS and addresses whose two low bits are not zero. Writes to such addresses change no flag.
- R9: When `bus_rd` and `bus_wr` are both high in one cycle, only the read is performed and the write is dropped.
- R10: At most one flag changes state in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_rd | input | 1 | Read strobe (test-and-set on flag words) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_ready` |
| bus_ready | output | 1 | Access completion, one cycle after the strobe |

## Verification
Several rules are checked by assertions on every cycle:
- the one-cycle ready handshake and the zero data outside a response;
- the status word's contents;
- zero data for undecoded reads;
- the rule that polling a taken flag, writing a nonzero value, or touching the status word leaves the whole flag vector unchanged;
- the bound of one flag change per cycle.

Other behaviours can only be shown by the bench's sweeps over all flags of the default bank:
- that a first claim returns 0 and a second returns 1;
- that a release frees exactly the addressed flag;
- that the word just past the bank is not an alias of flag 0 or flag 1;
- that a combined read and write keeps the flag taken.

// File: rtl/hwm_pkg.sv
package hwm_pkg;

    localparam int unsigned DATA_W      = 32;
    localparam int unsigned FLAG_BASE   = 'h800;
    localparam int unsigned STATUS_ADDR = 'h014;
    localparam int unsigned COUNT_LSB   = 24;
    localparam int unsigned GROUP_SIZE  = 32;

    typedef struct packed {
        logic              ready;
        logic [DATA_W-1:0] rdata;
    } rsp_t;

    function automatic logic [DATA_W-1:0] status_word(input int unsigned n_locks);
        logic [DATA_W-1:0] w;
        w = '0;
        w[COUNT_LSB +: 4] = 4'(n_locks / GROUP_SIZE);
        return w;
    endfunction

endpackage

// File: rtl/hwm_decode.sv
module hwm_decode #(
    parameter int unsigned NUM_LOCKS = 32,
    parameter int unsigned ADDR_W    = 12,
    localparam int unsigned IDX_W    = $clog2(NUM_LOCKS)
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              flag_hit_o,
    output logic [IDX_W-1:0]  flag_idx_o,
    output logic              status_hit_o
);
    import hwm_pkg::*;

    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(FLAG_BASE);
    localparam logic [ADDR_W-1:0] END_A  = ADDR_W'(FLAG_BASE + 4 * NUM_LOCKS);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_ADDR);

    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset       = addr_i - BASE_A;
        flag_hit_o   = (addr_i >= BASE_A) && (addr_i < END_A) && (addr_i[1:0] == 2'b00);
        flag_idx_o   = offset[IDX_W+1:2];
        status_hit_o = (addr_i == STAT_A);
    end

endmodule

// File: rtl/hwm_flag_cell.sv
module hwm_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (set_i)      flag_d = 1'b1;
        else if (clr_i) flag_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/hwm_flag_array.sv
module hwm_flag_array #(
    parameter int unsigned NUM_LOCKS = 32,
    localparam int unsigned IDX_W    = $clog2(NUM_LOCKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             claim_i,
    input  logic             release_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic             prev_o,
    output logic [NUM_LOCKS-1:0] flags_o
);
    logic [NUM_LOCKS-1:0] flags;

    for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_cell
        logic sel;
        assign sel = (idx_i == IDX_W'(g));
        hwm_flag_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (claim_i && sel),
            .clr_i  (release_i && !claim_i && sel),
            .flag_o (flags[g])
        );
    end

    assign prev_o  = flags[idx_i];
    assign flags_o = flags;

    // R4
    poll_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_i && prev_o) |=> (flags == $past(flags)));

    // R10
    single_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(flags ^ $past(flags)) <= 1);

    // R3
    claim_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        claim_i |=> flags[$past(idx_i)]);

endmodule

// File: rtl/hw_mutex_bank.sv
module hw_mutex_bank #(
    parameter int unsigned NUM_LOCKS = 32,
    parameter int unsigned ADDR_W    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_ready
);
    import hwm_pkg::*;

    localparam int unsigned IDX_W = $clog2(NUM_LOCKS);
    localparam logic [DATA_W-1:0] STATUS_VAL = status_word(NUM_LOCKS);

    initial begin
        if (!(NUM_LOCKS inside {32, 64, 128, 256}))
            $error("NUM_LOCKS must be 32, 64, 128 or 256");
    end

    logic             flag_hit, status_hit, prev_flag;
    logic [IDX_W-1:0] flag_idx;
    logic [NUM_LOCKS-1:0] flags;
    logic             claim, release_w;
    rsp_t             rsp_d, rsp_q;

    hwm_decode #(.NUM_LOCKS(NUM_LOCKS), .ADDR_W(ADDR_W)) u_decode (
        .addr_i       (bus_addr),
        .flag_hit_o   (flag_hit),
        .flag_idx_o   (flag_idx),
        .status_hit_o (status_hit)
    );

    assign claim     = bus_rd && flag_hit;
    assign release_w = bus_wr && !bus_rd && flag_hit && (bus_wdata == '0);

    hwm_flag_array #(.NUM_LOCKS(NUM_LOCKS)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .claim_i   (claim),
        .release_i (release_w),
        .idx_i     (flag_idx),
        .prev_o    (prev_flag),
        .flags_o   (flags)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.ready = bus_rd || bus_wr;
        if (bus_rd) begin
            if (flag_hit)        rsp_d.rdata = {31'b0, prev_flag};
            else if (status_hit) rsp_d.rdata = STATUS_VAL;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign bus_ready = rsp_q.ready;
    assign bus_rdata = rsp_q.rdata;

    // R2
    ready_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |=> bus_ready);

    // R2
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd || bus_wr) |=> !bus_ready);

    // R2
    quiet_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ready |-> (bus_rdata == '0));

    // R7
    status_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && status_hit) |=> (bus_rdata == STATUS_VAL));

    // R7
    status_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_hit |=> $stable(flags));

    // R8
    miss_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !flag_hit && !status_hit) |=> (bus_rdata == '0));

    // R8
    miss_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_hit |=> $stable(flags));

    // R6
    nonzero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_rd && (bus_wdata != '0)) |=> $stable(flags));

endmodule

// File: tb/hw_mutex_bank_bench.sv
module hw_mutex_bank_bench;

    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit model [N];

    always #5 clk = ~clk;

    hw_mutex_bank #(.NUM_LOCKS(N), .ADDR_W(12)) u_hw_mutex_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ready (bus_ready)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic access(input bit rd, input bit wr, input logic [11:0] a,
                          input logic [31:0] wd, output logic [31:0] rdv);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        @(negedge clk);
        chk("R2 ready", {31'b0, bus_ready}, 32'd1);
        rdv = bus_rdata;
        bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    function automatic logic [11:0] faddr(input int i);
        return 12'(32'h800 + 4 * i);
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ready", {31'b0, bus_ready}, 32'd0);
        chk("R1 rdata", bus_rdata, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 idle ready", {31'b0, bus_ready}, 32'd0);

        // R1/R3: every flag free after reset, first claim returns 0
        for (int i = 0; i < N; i++) begin
            access(1, 0, faddr(i), 0, r);
            chk("R3 first claim", r, 32'd0);
            model[i] = 1'b1;
        end
        // R4: second read returns 1
        for (int i = 0; i < N; i++) begin
            access(1, 0, faddr(i), 0, r);
            chk("R4 poll taken", r, 32'd1);
        end
        // R7 status word and status write ignored
        access(1, 0, 12'h014, 0, r);
        chk("R7 status", r, 32'(N / 32) << 24);
        access(0, 1, 12'h014, 32'hFFFF_FFFF, r);
        chk("R2 write rdata", r, 32'd0);
        access(1, 0, 12'h014, 0, r);
        chk("R7 status after write", r, 32'(N / 32) << 24);

        // R5 release evens, R6 nonzero writes to odds
        for (int i = 0; i < N; i++) begin
            if (i % 2 == 0) begin access(0, 1, faddr(i), 0, r); model[i] = 1'b0; end
            else access(0, 1, faddr(i), 32'(i + 1), r);
        end
        for (int i = 0; i < N; i++) begin
            access(1, 0, faddr(i), 0, r);
            chk((i % 2 == 0) ? "R5 released" : "R6 nonzero ignored", r, {31'b0, model[i]});
            model[i] = 1'b1;
        end

        // R8: release flag 0, touch word just past the bank and unaligned words
        access(0, 1, faddr(0), 0, r); model[0] = 1'b0;
        access(1, 0, faddr(N), 0, r);
        chk("R8 beyond read", r, 32'd0);
        access(1, 0, faddr(0) + 12'd1, 0, r);
        chk("R8 unaligned read", r, 32'd0);
        access(1, 0, 12'h010, 0, r);
        chk("R8 other offset read", r, 32'd0);
        access(0, 1, faddr(N + 1), 0, r);
        access(0, 1, faddr(1) + 12'd2, 0, r);
        access(1, 0, faddr(0), 0, r);
        chk("R8 flag0 untouched", r, 32'd0);
        access(1, 0, faddr(1), 0, r);
        chk("R8 flag1 untouched", r, 32'd1);

        // R9: combined read and zero-write on a free flag
        access(0, 1, faddr(5), 0, r);
        access(1, 1, faddr(5), 0, r);
        chk("R9 combined claims", r, 32'd0);
        access(1, 0, faddr(5), 0, r);
        chk("R9 write dropped", r, 32'd1);

        // R10: releasing one flag leaves its neighbours taken
        access(0, 1, faddr(N - 1), 0, r);
        access(1, 0, faddr(N - 2), 0, r);
        chk("R10 neighbour kept", r, 32'd1);
        access(1, 0, faddr(N - 1), 0, r);
        chk("R10 target freed", r, 32'd0);

        @(negedge clk);
        chk("R2 idle after traffic", {31'b0, bus_ready}, 32'd0);
        chk("R2 idle data", bus_rdata, 32'd0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule